// File: doc/BRIEF.md
# Multi-Mode Interval Timer Channel

This block is one down-counting timer channel. A control write picks one of six operating modes and either plain binary or four-digit BCD counting. A load strobe delivers a count value that an upstream bus block has already assembled. The channel then turns the count clock into one of six output waveforms on `out`:
- a level that is set at terminal count,
- a one-shot pulse that can be retriggered,
- a divide-by-N tick,
- a square wave,
- a strobe started by the load,
- a strobe started by the gate.

The live counter value is always visible on `count`, so a separate latch block can read it. The count clock is `clk`. Each enabled edge moves the counter by exactly one step. An input named `gate` controls counting. In the level-gated modes it pauses the counter. In the two edge-triggered modes a rising edge on it starts a count. A load value of zero stands for the longest period: 65536 in binary and 10000 in BCD.

Top module: `tmr_channel`

## Requirements
- R1: After reset the channel is in mode 0 with binary counting and idle. `out` is low and `count` is 0.
- R2: Each enabled step decrements `count` by one, modulo 65536 in binary. A load value of 0 gives a 65536-step period, so after one step from 0 `count` reads 0xFFFF.
- R3: Mode 0 (code 0): the load sets `out` low and starts counting on the following edges. `out` goes high at the edge where `count` becomes 0. It stays high, while counting continues and wraps, until the next mode write or load.
- R4: Mode 0: a `hold_req` pulse freezes `count`. The next load restarts counting from the new value with `out` low. `hold_req` has no effect in any other mode.
- R5: Mode 1 (code 1): a load only stores the value. A gate rising edge after a load copies the stored value into `count` and drives `out` low. `out` returns high when `count` reaches 0, and counting then stops. A new gate rising edge restarts the count at any time.
- R6: Mode 2 (codes 2 and 6): with a stored value N ≥ 2, the counter runs N, N−1, … 1 and then reloads N on the next step. `out` is low for exactly the one clock after each reload and high otherwise.
- R7: Mode 3 (codes 3 and 7): the counter reloads like mode 2. `out` is high while the value counted down is above floor(N/2) and low otherwise. For odd N the high part is one clock longer than the low part.
- R8: Mode 4 (code 4): the load starts counting with `out` high. When `count` reaches 0, `out` is low for exactly one clock and counting stops.
- R9: Mode 5 (code 5): behaves like mode 4, except that counting starts from the stored value on a gate rising edge instead of at the load. It can be retriggered.
- R10: With BCD selected, `count` holds four decimal digits, with the lowest digit in bits 3:0. A step borrows decimally, 0x0000 steps to 0x9999, and a load of 0 gives a 10000-step period.
- R11: In modes 0, 2, 3 and 4 a low `gate` holds `count` unchanged. In modes 1 and 5 the gate level has no effect once counting has begun.
- R12: A mode write stops counting and leaves `count` unchanged. It sets `out` low for mode 0 and high for every other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock; every state change happens on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | One-cycle strobe that applies `mode_code` and `bcd_sel` |
| mode_code | input | 3 | Operating mode code 0 to 7 (6 and 7 act as 2 and 3) |
| bcd_sel | input | 1 | 1 selects four-digit BCD counting, 0 selects binary |
| load_wr | input | 1 | One-cycle strobe carrying a complete count value |
| load_val | input | 16 | Count value to store (0 means the full range) |
| hold_req | input | 1 | One-cycle strobe: first half of a new count arrived (mode 0 freeze) |
| gate | input | 1 | Gate: level enable or edge trigger, depending on mode |
| out | output | 1 | Timer waveform output |
| count | output | 16 | Live counter value |

## Verification
Random sessions cover every mode code in both number systems, with small counts and a gate that is mostly high. They are mixed with loads and hold pulses in the middle of a count. This shows whether gate-level pausing and gate-edge triggering are sorted into the right modes, and whether a reload restarts correctly. A reference model computed from the remaining length in plain integers is compared with `out` and `count` on every cycle. Directed cases fill the gaps:
- the full-range load in binary and in BCD, which exposes the borrow chain and the 0→max wrap;
- an odd square-wave count, which separates the ceiling from the floor split;
- the mode 0 freeze and restart;
- gate low in a level-gated mode compared with a one-shot.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int CNT_W  = 16;
  localparam int DIGITS = CNT_W / 4;
  localparam int LEN_W  = CNT_W + 1;

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [LEN_W-1:0] len_t;

  typedef enum logic [2:0] {
    M_TC_INT  = 3'd0,
    M_ONESHOT = 3'd1,
    M_RATE    = 3'd2,
    M_SQUARE  = 3'd3,
    M_SW_STB  = 3'd4,
    M_HW_STB  = 3'd5
  } mode_e;

  // codes 6 and 7 alias the periodic modes
  function automatic mode_e decode_mode(input logic [2:0] code);
    case (code)
      3'd6:    return M_RATE;
      3'd7:    return M_SQUARE;
      default: return mode_e'(code);
    endcase
  endfunction

  // one step down in the selected number system, wrapping at zero
  function automatic cnt_t dec_count(input cnt_t v, input logic bcd);
    cnt_t r;
    logic borrow;
    logic [3:0] dig;
    if (!bcd) return v - cnt_t'(1);
    r = v;
    borrow = 1'b1;
    for (int i = 0; i < DIGITS; i++) begin
      dig = v[4*i +: 4];
      if (borrow) begin
        if (dig == 4'd0) begin
          dig = 4'd9;
          borrow = 1'b1;
        end else begin
          dig = dig - 4'd1;
          borrow = 1'b0;
        end
      end
      r[4*i +: 4] = dig;
    end
    return r;
  endfunction

  // numeric magnitude of a counter word
  function automatic len_t count_value(input cnt_t v, input logic bcd);
    len_t acc;
    if (!bcd) return len_t'(v);
    acc = '0;
    for (int i = DIGITS - 1; i >= 0; i--)
      acc = acc * len_t'(10) + len_t'(v[4*i +: 4]);
    return acc;
  endfunction

  function automatic len_t full_range(input logic bcd);
    len_t acc;
    if (!bcd) return len_t'(1) << CNT_W;
    acc = len_t'(1);
    for (int i = 0; i < DIGITS; i++) acc = acc * len_t'(10);
    return acc;
  endfunction

  // period length in steps; a zero word means the full range
  function automatic len_t period_len(input cnt_t v, input logic bcd);
    if (v == '0) return full_range(bcd);
    return count_value(v, bcd);
  endfunction

endpackage

// File: rtl/tmr_gate_edge.sv
module tmr_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  output logic rise
);
  logic gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate;
  end

  assign rise = gate & ~gate_q;

  // R9
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/tmr_down_counter.sv
module tmr_down_counter
  import tmr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ld,
  input  cnt_t ld_val,
  input  logic step,
  input  logic bcd,
  output cnt_t cnt
);
  cnt_t cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (ld)   cnt_q <= ld_val;
    else if (step) cnt_q <= dec_count(cnt_q, bcd);
  end

  assign cnt = cnt_q;

  // R2
  step_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld) |=> cnt_q == dec_count($past(cnt_q), $past(bcd)));

  // R10
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> cnt_q == $past(ld_val));

endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_wr,
  input  logic [2:0] mode_code,
  input  logic       bcd_sel,
  input  logic       load_wr,
  input  cnt_t       load_val,
  input  logic       hold_req,
  input  logic       gate,
  input  logic       gate_rise,
  input  cnt_t       cnt,
  output logic       ld,
  output cnt_t       ld_val,
  output logic       step,
  output logic       bcd_q,
  output logic       out
);
  mode_e mode_q, mode_n;
  cnt_t  reload_q, reload_n;
  logic  bcd_n, run_q, run_n, armed_q, armed_n, out_q, out_n;

  logic  level_gated, edge_started, trig, advance, at_one, pulse_mode;
  cnt_t  cnt_dec;
  len_t  half_len;

  assign level_gated  = mode_q inside {M_TC_INT, M_RATE, M_SQUARE, M_SW_STB};
  assign edge_started = mode_q inside {M_ONESHOT, M_HW_STB};
  assign pulse_mode   = mode_q inside {M_RATE, M_SW_STB, M_HW_STB};
  assign trig         = edge_started && armed_q && gate_rise;
  assign advance      = run_q && (gate || !level_gated);
  assign at_one       = (cnt == cnt_t'(1));
  assign cnt_dec      = dec_count(cnt, bcd_q);
  assign half_len     = period_len(reload_q, bcd_q) >> 1;

  always_comb begin
    mode_n   = mode_q;
    bcd_n    = bcd_q;
    reload_n = reload_q;
    run_n    = run_q;
    armed_n  = armed_q;
    out_n    = (pulse_mode && !out_q) ? 1'b1 : out_q;
    ld       = 1'b0;
    ld_val   = reload_q;
    step     = 1'b0;
    if (mode_wr) begin
      mode_n  = decode_mode(mode_code);
      bcd_n   = bcd_sel;
      run_n   = 1'b0;
      armed_n = 1'b0;
      out_n   = (decode_mode(mode_code) != M_TC_INT);
    end else if (load_wr) begin
      reload_n = load_val;
      armed_n  = 1'b1;
      if (!edge_started) begin
        ld     = 1'b1;
        ld_val = load_val;
        run_n  = 1'b1;
        out_n  = (mode_q != M_TC_INT);
      end
    end else if (hold_req && mode_q == M_TC_INT) begin
      run_n = 1'b0;
    end else if (trig) begin
      ld    = 1'b1;
      run_n = 1'b1;
      out_n = (mode_q == M_HW_STB);
    end else if (advance) begin
      case (mode_q)
        M_TC_INT: begin
          step = 1'b1;
          if (at_one) out_n = 1'b1;
        end
        M_ONESHOT: begin
          step = 1'b1;
          if (at_one) begin
            out_n = 1'b1;
            run_n = 1'b0;
          end
        end
        M_RATE: begin
          if (at_one) begin
            ld    = 1'b1;
            out_n = 1'b0;
          end else begin
            step = 1'b1;
          end
        end
        M_SQUARE: begin
          if (at_one) begin
            ld    = 1'b1;
            out_n = 1'b1;
          end else begin
            step  = 1'b1;
            out_n = (count_value(cnt_dec, bcd_q) > half_len);
          end
        end
        default: begin
          step = 1'b1;
          if (at_one) begin
            out_n = 1'b0;
            run_n = 1'b0;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= M_TC_INT;
      bcd_q    <= 1'b0;
      reload_q <= '0;
      run_q    <= 1'b0;
      armed_q  <= 1'b0;
      out_q    <= 1'b0;
    end else begin
      mode_q   <= mode_n;
      bcd_q    <= bcd_n;
      reload_q <= reload_n;
      run_q    <= run_n;
      armed_q  <= armed_n;
      out_q    <= out_n;
    end
  end

  assign out = out_q;

  // R8
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q inside {M_SW_STB, M_HW_STB} && !out_q && !mode_wr) |=> out_q);

  // R3
  tc_level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_TC_INT && out_q && !mode_wr && !load_wr) |=> out_q);

  // R11
  gate_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && level_gated && !gate && !mode_wr && !load_wr && !hold_req)
      |=> $stable(cnt));

  // R5
  oneshot_low_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_ONESHOT && !out_q) |-> run_q);

  // R12
  mode_write_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (!run_q && $stable(cnt)));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_wr,
  input  logic [2:0]       mode_code,
  input  logic             bcd_sel,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_val,
  input  logic             hold_req,
  input  logic             gate,
  output logic             out,
  output logic [CNT_W-1:0] count
);
  logic gate_rise, ld, step, bcd_q;
  cnt_t ld_val, cnt;

  tmr_gate_edge u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .gate (gate),
    .rise (gate_rise)
  );

  tmr_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_wr  (mode_wr),
    .mode_code(mode_code),
    .bcd_sel  (bcd_sel),
    .load_wr  (load_wr),
    .load_val (load_val),
    .hold_req (hold_req),
    .gate     (gate),
    .gate_rise(gate_rise),
    .cnt      (cnt),
    .ld       (ld),
    .ld_val   (ld_val),
    .step     (step),
    .bcd_q    (bcd_q),
    .out      (out)
  );

  tmr_down_counter u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (ld),
    .ld_val(ld_val),
    .step  (step),
    .bcd   (bcd_q),
    .cnt   (cnt)
  );

  assign count = cnt;

endmodule

// File: tb/tmr_channel_tb_top.sv
`timescale 1ns/1ps
module tmr_channel_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_wr = 1'b0;
  logic [2:0]  mode_code = '0;
  logic        bcd_sel = 1'b0;
  logic        load_wr = 1'b0;
  logic [15:0] load_val = '0;
  logic        hold_req = 1'b0;
  logic        gate = 1'b0;
  logic        out;
  logic [15:0] count;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit run_chk = 1'b0;

  always #2 clk = ~clk;

  tmr_channel dut_i (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_code(mode_code),
    .bcd_sel(bcd_sel), .load_wr(load_wr), .load_val(load_val),
    .hold_req(hold_req), .gate(gate), .out(out), .count(count)
  );

  // ---------------- reference model (remaining length as an integer)
  int m_mode, m_rem, m_len;
  bit m_bcd, m_out, m_run, m_armed, m_val, m_gq, m_gok;

  function automatic logic [15:0] to_bcd(input int x);
    return {4'(x / 1000 % 10), 4'(x / 100 % 10), 4'(x / 10 % 10), 4'(x % 10)};
  endfunction

  function automatic int len_of(input logic [15:0] v, input bit b);
    if (v == 16'h0) return b ? 10000 : 65536;
    if (b) return v[15:12] * 1000 + v[11:8] * 100 + v[7:4] * 10 + v[3:0];
    return int'(v);
  endfunction

  function automatic logic [15:0] shown(input int r, input bit b);
    if (b) return to_bcd(r % 10000);
    return 16'(r % 65536);
  endfunction

  function automatic int map_mode(input int c);
    return (c > 5) ? c - 4 : c;
  endfunction

  function automatic string out_tag(input int m);
    case (m)
      0: return "R3";
      1: return "R5";
      2: return "R6";
      3: return "R7";
      4: return "R8";
      default: return "R9";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_bcd = 0; m_out = 0; m_run = 0; m_armed = 0;
      m_rem = 0; m_len = 0; m_val = 1; m_gq = 0;
    end else begin
      m_gok = gate || m_mode == 1 || m_mode == 5;
      if ((m_mode == 2 || m_mode == 4 || m_mode == 5) && !m_out) m_out = 1;
      if (mode_wr) begin
        m_mode = map_mode(int'(mode_code)); m_bcd = bcd_sel;
        m_run = 0; m_armed = 0; m_out = (m_mode != 0); m_val = 0;
      end else if (load_wr) begin
        m_len = len_of(load_val, m_bcd); m_armed = 1;
        if (m_mode != 1 && m_mode != 5) begin
          m_rem = m_len; m_run = 1; m_out = (m_mode != 0); m_val = 1;
        end
      end else if (hold_req && m_mode == 0) begin
        m_run = 0;
      end else if ((m_mode == 1 || m_mode == 5) && m_armed && gate && !m_gq) begin
        m_rem = m_len; m_run = 1; m_out = (m_mode == 5); m_val = 1;
      end else if (m_run && m_gok) begin
        case (m_mode)
          0: begin
            m_rem = (m_rem == 0) ? (m_bcd ? 9999 : 65535) : m_rem - 1;
            if (m_rem == 0) m_out = 1;
          end
          1: begin
            m_rem = m_rem - 1;
            if (m_rem == 0) begin m_out = 1; m_run = 0; end
          end
          2: begin
            if (m_rem == 1) begin m_rem = m_len; m_out = 0; end
            else m_rem = m_rem - 1;
          end
          3: begin
            if (m_rem == 1) m_rem = m_len; else m_rem = m_rem - 1;
            m_out = (m_rem > m_len / 2);
          end
          default: begin
            m_rem = m_rem - 1;
            if (m_rem == 0) begin m_out = 0; m_run = 0; end
          end
        endcase
      end
      m_gq = gate;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act,
                     input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (run_chk) begin
      chk(out_tag(m_mode), 32'(out), 32'(m_out), "out vs model");
      if (m_val) chk(m_bcd ? "R10" : "R2", 32'(count), 32'(shown(m_rem, m_bcd)),
                     "count vs model");
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus helpers (called at a falling edge)
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input int m, input bit b);
    mode_wr = 1; mode_code = 3'(m); bcd_sel = b;
    @(negedge clk);
    mode_wr = 0;
  endtask

  task automatic do_load(input logic [15:0] v);
    load_wr = 1; load_val = v;
    @(negedge clk);
    load_wr = 0;
  endtask

  logic [15:0] snap;
  int exp_sq[6] = '{1, 1, 1, 0, 0, 1};

  initial begin
    void'($urandom(32'd20240611));
    tick(3);
    rst_n = 1;
    tick(1);
    // R1 reset state
    chk("R1", 32'(out), 32'd0, "out after reset");
    chk("R1", 32'(count), 32'd0, "count after reset");
    run_chk = 1;
    gate = 1;

    // R12 mode write level and freeze
    set_mode(4, 0);
    chk("R12", 32'(out), 32'd1, "out after mode 4 write");
    do_load(16'd40);
    tick(5);
    set_mode(0, 0);
    chk("R12", 32'(out), 32'd0, "out after mode 0 write");
    snap = count;
    tick(3);
    chk("R12", 32'(count), 32'(snap), "count frozen after mode write");

    // R4 mode 0 freeze and restart
    do_load(16'd50);
    tick(5);
    chk("R3", 32'(count), 32'd45, "mode 0 count after 5 steps");
    hold_req = 1; tick(1); hold_req = 0;
    snap = count;
    tick(3);
    chk("R4", 32'(count), 32'(snap), "count frozen by hold");
    do_load(16'd7);
    chk("R4", 32'(count), 32'd7, "restart value");
    chk("R4", 32'(out), 32'd0, "out low on restart");
    tick(6);
    chk("R3", 32'(out), 32'd0, "out before terminal count");
    tick(1);
    chk("R3", 32'(out), 32'd1, "out at terminal count");
    tick(2);
    chk("R3", 32'(count), 32'hFFFE, "counting continues past zero");

    // R2 full range binary
    do_load(16'h0000);
    tick(1);
    chk("R2", 32'(count), 32'hFFFF, "zero load wraps to max");

    // R11 gate low in mode 2 versus mode 1
    set_mode(2, 0);
    gate = 0;
    do_load(16'd20);
    tick(6);
    chk("R11", 32'(count), 32'd20, "mode 2 paused by gate");
    gate = 1;
    set_mode(1, 0);
    gate = 0;
    do_load(16'd30);
    chk("R5", 32'(out), 32'd1, "mode 1 out high before trigger");
    tick(1);
    gate = 1;
    tick(1);
    chk("R5", 32'(count), 32'd30, "mode 1 trigger value");
    chk("R5", 32'(out), 32'd0, "mode 1 out low after trigger");
    gate = 0;
    tick(4);
    chk("R11", 32'(count), 32'd26, "mode 1 ignores gate level");
    gate = 1;

    // R7 odd square wave
    set_mode(3, 0);
    do_load(16'd5);
    for (int i = 0; i < 6; i++) begin
      chk("R7", 32'(out), 32'(exp_sq[i]), "square wave N=5");
      tick(1);
    end

    // R6 alias code 6
    set_mode(6, 0);
    do_load(16'd3);
    tick(2);
    chk("R6", 32'(out), 32'd1, "rate before reload");
    tick(1);
    chk("R6", 32'(out), 32'd0, "rate low clock");
    chk("R6", 32'(count), 32'd3, "rate reload");

    // R10 full range BCD
    set_mode(0, 1);
    do_load(16'h0000);
    tick(1);
    chk("R10", 32'(count), 32'h9999, "BCD zero wraps to 9999");
    tick(9998);
    chk("R10", 32'(out), 32'd0, "BCD out before 10000 steps");
    tick(1);
    chk("R10", 32'(out), 32'd1, "BCD out after 10000 steps");

    // random sessions
    for (int s = 0; s < 60; s++) begin
      int m, n, len;
      bit b;
      m = int'($urandom % 8);
      b = 1'($urandom % 2);
      n = 2 + int'($urandom % 30);
      gate = 1;
      set_mode(m, b);
      do_load(b ? to_bcd(n) : 16'(n));
      len = n * 3 + 5;
      for (int c = 0; c < len; c++) begin
        int r, n2;
        r = int'($urandom % 100);
        n2 = 2 + int'($urandom % 30);
        if (map_mode(m) == 1 || map_mode(m) == 5) gate = ($urandom % 5) != 0;
        else gate = ($urandom % 10) != 0;
        load_wr = (r < 2);
        load_val = b ? to_bcd(n2) : 16'(n2);
        hold_req = (r >= 2 && r < 4);
        tick(1);
      end
      load_wr = 0;
      hold_req = 0;
    end

    run_chk = 0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule